// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block turns a four-row display bitmap into the drive levels for a passive LCD. It has four backplane outputs and a parameterized number of segment outputs. Each output is a 2-bit code that picks one of four bias levels: ground, one third, two thirds, or the full LCD voltage. The analog stage outside the block turns each code into a voltage. A frame always lasts a fixed number of drive steps (24 by default). The frame is split into one to four backplane time slots, according to the selected multiplex ratio. Each slot has two halves of opposite polarity, so the liquid crystal sees no net DC.

The drive step comes from one of two sources. The first is a divided version of the block clock, which acts as the internal oscillator. The second is the rising edges of an external clock pin, which is first brought into the clock domain. The multiplex ratio comes from a plain configuration input. A new ratio is taken up only when a frame ends, so a frame never mixes two slot layouts. When fewer than four backplanes are in use, the spare backplane pins repeat the waveform of a used one, so they can be tied together for extra drive.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the sequencer to slot 0, first half, step 0 of the frame. It also loads the active ratio from `cfg_mode`. The outputs show that position in the cycle right after reset is released.
- R2: Level codes are 0 = ground, 1 = one third, 2 = two thirds, 3 = full. A backplane whose slot is active outputs 3 in the first half and 0 in the second half. Every other backplane outputs 2 in the first half and 1 in the second half.
- R3: Segment n reads bit `r*NUM_SEG + n` of `disp_map`, where r is the active slot. When that bit is 1, the segment outputs 0 in the first half and 3 in the second half. When it is 0, the segment outputs 1 in the first half and 2 in the second half.
- R4: A frame is FRAME_LEN drive steps long. With S slots, each half lasts FRAME_LEN/(2*S) steps. The slots run in order 0 to S-1, and the frame wraps back to slot 0.
- R5: `cfg_mode` encodes the ratio as 0 = static (1 slot), 1 = 1:2, 2 = 1:3, 3 = 1:4. Backplane k follows slot k in 1:4 mode. In 1:3 mode, backplane 3 follows slot 1. In 1:2 mode, backplanes 0 and 2 follow slot 0, and backplanes 1 and 3 follow slot 1. In static mode, all four follow slot 0.
- R6: A change on `cfg_mode` takes effect only when the frame wraps from its last step back to step 0. Until then, the current frame runs to its end in the old ratio.
- R7: With `sel_int_osc` = 1, the sequencer advances one drive step every OSC_DIV clocks, and `ext_clk` has no effect. Counting clock edges from reset release, the position after edge m is floor(m/OSC_DIV).
- R8: With `sel_int_osc` = 0, each rising edge of `ext_clk` advances the sequencer by exactly one step, after a two-stage synchronizer. Holding `ext_clk` high does not advance it further, and a falling edge does not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the internal oscillator source |
| rst | input | 1 | Synchronous reset, active high |
| sel_int_osc | input | 1 | 1 = step from the internal divider, 0 = step from `ext_clk` |
| ext_clk | input | 1 | External drive clock, asynchronous to `clk` |
| cfg_mode | input | 2 | Multiplex ratio code (R5) |
| disp_map | input | 4*NUM_SEG | Display bitmap, row-major, 1 = element on |
| bp_level | output | 8 | Backplane level codes, backplane k at bits [2k+1:2k] |
| seg_level | output | 2*NUM_SEG | Segment level codes, segment n at bits [2n+1:2n] |

## Verification
The bench builds the block with NUM_SEG = 8 and OSC_DIV = 4, keeping FRAME_LEN at 24. With eight segments, every output can be compared on every step. This makes it possible to sweep all four ratios over every one of the 24 frame positions under several bitmaps. The short divider lets the internal-clock run be checked edge by edge over more than a full frame. The ratio-change, reset-mid-frame and held-external-clock cases also fit inside a few hundred cycles.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int NUM_BP = 4;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_2      = 2'd1,
    MUX_3      = 2'd2,
    MUX_4      = 2'd3
  } mux_mode_e;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_VSS       = 2'd0;
  localparam lvl_t LVL_THIRD     = 2'd1;
  localparam lvl_t LVL_TWO_THIRD = 2'd2;
  localparam lvl_t LVL_FULL      = 2'd3;

  // Which time slot a backplane pin follows under a given ratio.
  function automatic logic [1:0] bp_slot(mux_mode_e mode, logic [1:0] pin);
    case (mode)
      MUX_STATIC: bp_slot = 2'd0;
      MUX_2:      bp_slot = {1'b0, pin[0]};
      MUX_3:      bp_slot = (pin == 2'd3) ? 2'd1 : pin;
      default:    bp_slot = pin;
    endcase
  endfunction
endpackage

// File: rtl/lcd_drive_tick.sv
module lcd_drive_tick #(
  parameter int OSC_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_int_osc,
  input  logic ext_clk,
  output logic drive_tick
);
  localparam int DW = (OSC_DIV > 2) ? $clog2(OSC_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(OSC_DIV - 1);

  logic [DW-1:0] div_q;
  logic [1:0]    sync_q;
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      div_q  <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      sync_q <= {sync_q[0], ext_clk};
      prev_q <= sync_q[1];
    end
  end

  assign drive_tick = sel_int_osc ? (div_q == DIV_LAST) : (sync_q[1] & ~prev_q);
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_seq_pkg::*;
#(
  parameter int FRAME_LEN = 24
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      drive_tick,
  input  logic [1:0] cfg_mode,
  output logic [1:0] slot,
  output logic      half,
  output mux_mode_e act_mode
);
  localparam int CW = $clog2(FRAME_LEN / 2 + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_len;
  logic          half_end;

  always_comb begin
    case (act_mode)
      MUX_STATIC: half_len = CW'(FRAME_LEN / 2);
      MUX_2:      half_len = CW'(FRAME_LEN / 4);
      MUX_3:      half_len = CW'(FRAME_LEN / 6);
      default:    half_len = CW'(FRAME_LEN / 8);
    endcase
  end

  assign half_end = (cnt_q == half_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      half     <= 1'b0;
      slot     <= 2'd0;
      act_mode <= mux_mode_e'(cfg_mode);
    end else if (drive_tick) begin
      if (!half_end) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        half  <= ~half;
        if (half) begin
          if (slot == 2'(act_mode)) begin
            slot     <= 2'd0;
            act_mode <= mux_mode_e'(cfg_mode);
          end else begin
            slot <= slot + 2'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 80
) (
  input  logic [1:0]                slot,
  input  logic                      half,
  input  mux_mode_e                 mode,
  input  logic [NUM_BP*NUM_SEG-1:0] disp_map,
  output logic [2*NUM_BP-1:0]       bp_level,
  output logic [2*NUM_SEG-1:0]      seg_level
);
  logic [NUM_SEG-1:0] row_bits;
  assign row_bits = disp_map[int'(slot)*NUM_SEG +: NUM_SEG];

  for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
    logic sel;
    assign sel = (bp_slot(mode, 2'(k)) == slot);
    assign bp_level[2*k +: 2] = sel ? (half ? LVL_VSS : LVL_FULL)
                                    : (half ? LVL_THIRD : LVL_TWO_THIRD);
  end

  for (genvar n = 0; n < NUM_SEG; n++) begin : g_seg
    assign seg_level[2*n +: 2] = row_bits[n] ? (half ? LVL_FULL : LVL_VSS)
                                             : (half ? LVL_TWO_THIRD : LVL_THIRD);
  end
endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG   = 80,
  parameter int OSC_DIV   = 64,
  parameter int FRAME_LEN = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sel_int_osc,
  input  logic                      ext_clk,
  input  logic [1:0]                cfg_mode,
  input  logic [NUM_BP*NUM_SEG-1:0] disp_map,
  output logic [2*NUM_BP-1:0]       bp_level,
  output logic [2*NUM_SEG-1:0]      seg_level
);
  logic      drive_tick;
  logic [1:0] slot;
  logic      half;
  mux_mode_e act_mode;

  lcd_drive_tick #(.OSC_DIV(OSC_DIV)) u_tick (
    .clk        (clk),
    .rst        (rst),
    .sel_int_osc(sel_int_osc),
    .ext_clk    (ext_clk),
    .drive_tick (drive_tick)
  );

  lcd_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .drive_tick(drive_tick),
    .cfg_mode  (cfg_mode),
    .slot      (slot),
    .half      (half),
    .act_mode  (act_mode)
  );

  lcd_level_map #(.NUM_SEG(NUM_SEG)) u_map (
    .slot     (slot),
    .half     (half),
    .mode     (act_mode),
    .disp_map (disp_map),
    .bp_level (bp_level),
    .seg_level(seg_level)
  );
endmodule

// File: rtl/lcd_mux_sequencer_chk.sv
module lcd_mux_sequencer_chk #(
  parameter int NUM_SEG = 80
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 drive_tick,
  input logic [1:0]           slot,
  input logic                 half,
  input logic [1:0]           act_mode,
  input logic [7:0]           bp_level,
  input logic [2*NUM_SEG-1:0] seg_level
);
  logic [3:0]         bp_extreme;
  logic [NUM_SEG-1:0] seg_hi;

  always_comb begin
    for (int k = 0; k < 4; k++) bp_extreme[k] = (bp_level[2*k] == bp_level[2*k+1]);
    for (int n = 0; n < NUM_SEG; n++) seg_hi[n] = seg_level[2*n+1];
  end

  assert_slot_range_R4: assert property (@(posedge clk) disable iff (rst)
    slot <= act_mode);

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (rst)
    !drive_tick |=> ($stable(slot) && $stable(half) && $stable(act_mode)));

  assert_mode_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (act_mode != $past(act_mode)) |-> (slot == 2'd0 && !half));

  assert_one_selected_R2: assert property (@(posedge clk) disable iff (rst)
    (act_mode == 2'd3) |-> ($countones(bp_extreme) == 1));

  assert_mirror_R5: assert property (@(posedge clk) disable iff (rst)
    (act_mode == 2'd0 && bp_level[1:0] == bp_level[3:2] && bp_level[1:0] == bp_level[5:4]
                      && bp_level[1:0] == bp_level[7:6])
    || (act_mode == 2'd1 && bp_level[1:0] == bp_level[5:4] && bp_level[3:2] == bp_level[7:6])
    || (act_mode == 2'd2 && bp_level[3:2] == bp_level[7:6])
    || (act_mode == 2'd3));

  assert_seg_polarity_R3: assert property (@(posedge clk) disable iff (rst)
    half ? (seg_hi == {NUM_SEG{1'b1}}) : (seg_hi == '0));
endmodule

bind lcd_mux_sequencer lcd_mux_sequencer_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .drive_tick(drive_tick),
  .slot      (slot),
  .half      (half),
  .act_mode  (act_mode),
  .bp_level  (bp_level),
  .seg_level (seg_level)
);

// File: tb/tb_lcd_mux_sequencer.sv
`timescale 1ns/1ps
module tb_lcd_mux_sequencer;
  localparam int NS   = 8;
  localparam int DIV  = 4;
  localparam int FLEN = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_int_osc = 1'b0;
  logic          ext_clk = 1'b0;
  logic [1:0]    cfg_mode = 2'd3;
  logic [4*NS-1:0] disp_map = '0;
  logic [7:0]    bp_level;
  logic [2*NS-1:0] seg_level;

  int total = 0;
  int bad = 0;
  int pos = 0;
  int mode_now = 3;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lcd_mux_sequencer #(.NUM_SEG(NS), .OSC_DIV(DIV), .FRAME_LEN(FLEN)) dut (
    .clk(clk), .rst(rst), .sel_int_osc(sel_int_osc), .ext_clk(ext_clk),
    .cfg_mode(cfg_mode), .disp_map(disp_map), .bp_level(bp_level), .seg_level(seg_level)
  );

  function automatic logic [7:0] exp_bp(int md, int p);
    int hl = FLEN / (2 * (md + 1));
    int sl = p / (2 * hl);
    int hf = (p / hl) % 2;
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin
      int bs = (md == 0) ? 0 : (md == 1) ? k % 2 : (md == 2) ? ((k == 3) ? 1 : k) : k;
      v[2*k +: 2] = (bs == sl) ? (hf ? 2'd0 : 2'd3) : (hf ? 2'd1 : 2'd2);
    end
    return v;
  endfunction

  function automatic logic [2*NS-1:0] exp_seg(int md, int p, logic [4*NS-1:0] m);
    int hl = FLEN / (2 * (md + 1));
    int sl = p / (2 * hl);
    int hf = (p / hl) % 2;
    logic [2*NS-1:0] v;
    for (int n = 0; n < NS; n++)
      v[2*n +: 2] = m[sl*NS + n] ? (hf ? 2'd3 : 2'd0) : (hf ? 2'd2 : 2'd1);
    return v;
  endfunction

  task automatic check_out(string tag);
    logic [7:0] eb = exp_bp(mode_now, pos);
    logic [2*NS-1:0] es = exp_seg(mode_now, pos, disp_map);
    total++;
    if (bp_level !== eb) begin
      bad++;
      $display("FAIL %s backplanes mode=%0d pos=%0d actual=%h expected=%h", tag, mode_now, pos, bp_level, eb);
    end
    total++;
    if (seg_level !== es) begin
      bad++;
      $display("FAIL %s segments mode=%0d pos=%0d actual=%h expected=%h", tag, mode_now, pos, seg_level, es);
    end
  endtask

  task automatic advance_model();
    pos = pos + 1;
    if (pos == FLEN) begin
      pos = 0;
      mode_now = int'(cfg_mode);
    end
  endtask

  task automatic ext_pulse();
    @(negedge clk) ext_clk = 1'b1;
    repeat (3) @(negedge clk);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    advance_model();
  endtask

  task automatic do_reset(int md);
    @(negedge clk);
    rst = 1'b1;
    cfg_mode = 2'(md);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    pos = 0;
    mode_now = md;
  endtask

  function automatic logic [4*NS-1:0] pattern(int seed);
    logic [4*NS-1:0] v;
    for (int i = 0; i < 4*NS; i++)
      v[i] = (seed == 2) ? 1'b1 : (((i * 7 + seed * 3) % 5) < 2);
    return v;
  endfunction

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    disp_map = pattern(0);
    do_reset(3);
    @(negedge clk);
    check_out("R1 after reset");

    // R2 R3 R4 R5: all ratios, all positions, several bitmaps
    for (int md = 0; md < 4; md++) begin
      do_reset(md);
      for (int pt = 0; pt < 3; pt++) begin
        disp_map = pattern(pt);
        for (int p = 0; p < FLEN; p++) begin
          @(negedge clk);
          check_out("R2/R3/R4/R5 sweep");
          ext_pulse();
        end
      end
    end

    // R1: reset in mid frame returns to step 0
    do_reset(3);
    repeat (7) ext_pulse();
    check_out("R4 mid frame");
    do_reset(3);
    @(negedge clk);
    check_out("R1 reset mid frame");

    // R6: ratio change waits for the frame wrap
    disp_map = pattern(1);
    repeat (5) ext_pulse();
    cfg_mode = 2'd1;
    for (int i = 0; i < 2 * FLEN; i++) begin
      check_out("R6 deferred ratio change");
      ext_pulse();
    end
    cfg_mode = 2'd2;
    for (int i = 0; i < FLEN + 3; i++) begin
      check_out("R6 second change");
      ext_pulse();
    end

    // R8: a held level and a falling edge give no extra steps
    do_reset(3);
    repeat (2) ext_pulse();
    @(negedge clk) ext_clk = 1'b1;
    repeat (20) @(negedge clk);
    advance_model();
    check_out("R8 held high");
    ext_clk = 1'b0;
    repeat (20) @(negedge clk);
    check_out("R8 after falling edge");
    ext_pulse();
    check_out("R8 next rising edge");

    // R7: internal divider, external pin toggling and ignored
    @(negedge clk);
    rst = 1'b1;
    sel_int_osc = 1'b1;
    cfg_mode = 2'd3;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mode_now = 3;
    for (int m = 1; m <= DIV * 28; m++) begin
      ext_clk = ((m / 3) % 2) == 1;
      @(posedge clk);
      @(negedge clk);
      pos = (m / DIV) % FLEN;
      check_out("R7 internal divider");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule